// File: doc/BRIEF.md
# Downward-Growing Stack Pointer Unit

This block holds a processor's stack pointer and works out how it changes. The stack fills from high addresses toward low ones. The core asserts one single-cycle strobe for each stack operation, and the block answers in the same cycle:

- A data push or a return-address push drives the memory address or addresses to write. The pointer then steps down by one or by two at the clock edge.
- A data pop or a return-address pop drives the address or addresses to read. The pointer then steps up by the same amount.

Software sees the pointer as a low byte register and a high byte register on a small I/O port. When the configured width is 8 bits or fewer, the high byte register is absent.

The block runs a push as write-then-decrement and a pop as increment-then-read. Two outputs, `addr0` and `addr1`, carry the addresses of the current operation. A push attempted while the pointer is at or below 0x40 raises a combinational misuse flag.

Top module: `stack_ptr_unit`

## Requirements
- R1: Reset loads the pointer with the parameter TOP_VALUE (default 0x25F for the 10-bit default width).
- R2: A data push (`push_data`) drives `addr0` = `addr1` = SP, and SP becomes SP-1 after the edge.
- R3: A return-address push (`push_ret`) drives `addr0` = SP (low byte of the return address) and `addr1` = SP-1 (high byte), and SP becomes SP-2.
- R4: A data pop (`pop_data`) drives `addr0` = `addr1` = SP+1, and SP becomes SP+1.
- R5: A return-address pop (`pop_ret`) drives `addr0` = SP+1 (high byte, read first) and `addr1` = SP+2 (low byte), and SP becomes SP+2.
- R6: `io_rdata` shows bits 7:0 of SP when `io_sel`=0 and bits 15:8 when `io_sel`=1. Bits at or above SP_W read as zero.
- R7: With `io_we`=1, `io_wdata` replaces the low byte (`io_sel`=0) or the high byte (`io_sel`=1) of SP. A push or pop strobe in the same cycle does not change SP.
- R8: When SP_W <= 8, the high byte reads as zero and writes to it leave SP unchanged.
- R9: Pointer arithmetic wraps modulo 2^SP_W, both for the pointer and for the address outputs.
- R10: `misuse` is 1 in a cycle with `push_data` or `push_ret` while SP <= 0x40. It is 0 for pops, for idle cycles, and for pushes above 0x40.
- R11: With no strobe and no write, SP holds, and `addr0` = `addr1` = SP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_data | input | 1 | Push one data byte |
| pop_data | input | 1 | Pop one data byte |
| push_ret | input | 1 | Push a two-byte return address |
| pop_ret | input | 1 | Pop a two-byte return address |
| io_we | input | 1 | I/O write strobe |
| io_sel | input | 1 | 0 selects the low byte register, 1 selects the high byte register |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data of the selected byte |
| addr0 | output | SP_W | First memory address of the current operation |
| addr1 | output | SP_W | Second memory address of the current operation |
| misuse | output | 1 | Push attempted with SP at or below 0x40 |

## Verification
The hardest cases to reach are the wrap corners, a return-address pop at the top of the space and a return-address push at address zero. In both, the two addresses fall on opposite sides of the modulo boundary. The stimulus first writes the pointer through the I/O bytes to 0x3FF or 0x3FE and then pops or pushes across zero. The misuse threshold is reached the same way: the pointer is written to 0x41 and pushed twice, which straddles the limit. A second, 8-bit instance shows that the high byte register is absent.

// File: rtl/stack_ptr_unit.sv
module stack_ptr_unit #(
  parameter int SP_W = 10,
  parameter logic [SP_W-1:0] TOP_VALUE = SP_W'(16'h025F)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push_data,
  input  logic            pop_data,
  input  logic            push_ret,
  input  logic            pop_ret,
  input  logic            io_we,
  input  logic            io_sel,
  input  logic [7:0]      io_wdata,
  output logic [7:0]      io_rdata,
  output logic [SP_W-1:0] addr0,
  output logic [SP_W-1:0] addr1,
  output logic            misuse
);

  localparam bit HAS_HI = SP_W > 8;
  localparam logic [SP_W-1:0] ONE = SP_W'(1);
  localparam logic [SP_W-1:0] TWO = SP_W'(2);

  logic [SP_W-1:0] sp, sp_next, sp_wr;
  logic [15:0]     sp16, wr16;

  assign sp16 = 16'(sp);

  always_comb begin
    if (io_sel) wr16 = HAS_HI ? {io_wdata, sp16[7:0]} : sp16;
    else        wr16 = {sp16[15:8], io_wdata};
  end
  assign sp_wr = SP_W'(wr16);

  always_comb begin
    sp_next = sp;
    if (io_we)          sp_next = sp_wr;
    else if (push_data) sp_next = sp - ONE;
    else if (push_ret)  sp_next = sp - TWO;
    else if (pop_data)  sp_next = sp + ONE;
    else if (pop_ret)   sp_next = sp + TWO;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sp <= TOP_VALUE;
    else        sp <= sp_next;
  end

  assign addr0    = (pop_data || pop_ret) ? sp + ONE : sp;
  assign addr1    = push_ret ? sp - ONE : (pop_ret ? sp + TWO : addr0);
  assign io_rdata = io_sel ? sp16[15:8] : sp16[7:0];
  assign misuse   = (push_data || push_ret) && (sp16 <= 16'h0040);

  p_strobe_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({push_data, pop_data, push_ret, pop_ret}));

  p_push_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    push_data && !io_we |=> sp == $past(sp) - ONE);

  p_call_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    push_ret && !io_we |=> sp == $past(sp) - TWO);

  p_pop_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pop_data && !io_we |=> sp == $past(sp) + ONE);

  p_ret_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pop_ret && !io_we |=> sp == $past(sp) + TWO);

  p_io_lo_r7: assert property (@(posedge clk) disable iff (!rst_n)
    io_we && !io_sel |=> io_sel || io_rdata == ($past(io_wdata) & 8'(16'(sp_wr | ~sp_wr))));

  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !io_we && !push_data && !pop_data && !push_ret && !pop_ret |=> $stable(sp));

  p_pop_clean_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_data || pop_ret) |-> !misuse);

endmodule

// File: tb/stack_ptr_unit_tb.sv
module stack_ptr_unit_tb;
  logic clk = 0;
  logic rst_n = 0;
  logic push_data = 0, pop_data = 0, push_ret = 0, pop_ret = 0, io_we = 0, io_sel = 0;
  logic [7:0] io_wdata = 0, io_rdata;
  logic [9:0] addr0, addr1;
  logic misuse;
  logic io_we8 = 0, io_sel8 = 0;
  logic [7:0] io_wdata8 = 0, io_rdata8, a0_8, a1_8;
  logic mis8;
  int checks = 0, failures = 0;

  always #4 clk = ~clk;

  stack_ptr_unit u_dut (.clk(clk), .rst_n(rst_n), .push_data(push_data), .pop_data(pop_data),
    .push_ret(push_ret), .pop_ret(pop_ret), .io_we(io_we), .io_sel(io_sel), .io_wdata(io_wdata),
    .io_rdata(io_rdata), .addr0(addr0), .addr1(addr1), .misuse(misuse));

  stack_ptr_unit #(.SP_W(8), .TOP_VALUE(8'hF0)) u_dut8 (.clk(clk), .rst_n(rst_n),
    .push_data(1'b0), .pop_data(1'b0), .push_ret(1'b0), .pop_ret(1'b0), .io_we(io_we8),
    .io_sel(io_sel8), .io_wdata(io_wdata8), .io_rdata(io_rdata8), .addr0(a0_8), .addr1(a1_8),
    .misuse(mis8));

  // op: 0 idle, 1 push data, 2 pop data, 3 push ret, 4 pop ret, 5 write low, 6 write high
  // fields: op[41:39] wdata[38:31] a0[30:21] a1[20:11] sp_after[10:1] misuse[0]
  localparam int NV = 16;
  localparam logic [41:0] VEC [NV] = '{
    {3'd1, 8'h00, 10'h25F, 10'h25F, 10'h25E, 1'b0},
    {3'd3, 8'h00, 10'h25E, 10'h25D, 10'h25C, 1'b0},
    {3'd2, 8'h00, 10'h25D, 10'h25D, 10'h25D, 1'b0},
    {3'd4, 8'h00, 10'h25E, 10'h25F, 10'h25F, 1'b0},
    {3'd6, 8'h00, 10'h25F, 10'h25F, 10'h05F, 1'b0},
    {3'd5, 8'h41, 10'h05F, 10'h05F, 10'h041, 1'b0},
    {3'd1, 8'h00, 10'h041, 10'h041, 10'h040, 1'b0},
    {3'd1, 8'h00, 10'h040, 10'h040, 10'h03F, 1'b1},
    {3'd3, 8'h00, 10'h03F, 10'h03E, 10'h03D, 1'b1},
    {3'd4, 8'h00, 10'h03E, 10'h03F, 10'h03F, 1'b0},
    {3'd6, 8'h03, 10'h03F, 10'h03F, 10'h33F, 1'b0},
    {3'd5, 8'hFF, 10'h33F, 10'h33F, 10'h3FF, 1'b0},
    {3'd2, 8'h00, 10'h000, 10'h000, 10'h000, 1'b0},
    {3'd3, 8'h00, 10'h000, 10'h3FF, 10'h3FE, 1'b1},
    {3'd4, 8'h00, 10'h3FF, 10'h000, 10'h000, 1'b0},
    {3'd0, 8'h00, 10'h000, 10'h000, 10'h000, 1'b0}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic read_sp(output logic [15:0] v);
    io_sel = 0; #1 v[7:0] = io_rdata;
    io_sel = 1; #1 v[15:8] = io_rdata;
    io_sel = 0;
  endtask

  function automatic string tag(input logic [2:0] op);
    case (op)
      3'd1: return "R2 push data";
      3'd2: return "R4 pop data";
      3'd3: return "R3 push ret";
      3'd4: return "R5 pop ret";
      3'd5: return "R7 write low";
      3'd6: return "R7 write high";
      default: return "R11 idle";
    endcase
  endfunction

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    read_sp(v);
    chk("R1 reset value", v, 16'h025F);
    io_sel8 = 0; #1 chk("R1 reset value 8-bit", {8'h00, io_rdata8}, 16'h00F0);

    for (int i = 0; i < NV; i++) begin
      logic [41:0] e;
      e = VEC[i];
      @(negedge clk);
      push_data = e[41:39] == 3'd1;
      pop_data  = e[41:39] == 3'd2;
      push_ret  = e[41:39] == 3'd3;
      pop_ret   = e[41:39] == 3'd4;
      io_we     = e[41:39] == 3'd5 || e[41:39] == 3'd6;
      io_sel    = e[41:39] == 3'd6;
      io_wdata  = e[38:31];
      #1;
      chk({tag(e[41:39]), " addr0 R9"}, {6'h0, addr0}, {6'h0, e[30:21]});
      chk({tag(e[41:39]), " addr1 R9"}, {6'h0, addr1}, {6'h0, e[20:11]});
      chk("R10 misuse", {15'h0, misuse}, {15'h0, e[0]});
      @(posedge clk);
      @(negedge clk);
      push_data = 0; pop_data = 0; push_ret = 0; pop_ret = 0; io_we = 0;
      read_sp(v);
      chk({tag(e[41:39]), " pointer after"}, v, {6'h0, e[10:1]});
    end

    // R7: a write wins over a push strobe in the same cycle
    @(negedge clk);
    io_we = 1; io_sel = 0; io_wdata = 8'h10; push_data = 1;
    @(posedge clk); @(negedge clk);
    io_we = 0; push_data = 0;
    read_sp(v);
    chk("R7 write over push", v, 16'h0010);

    // R6: high bits beyond the width read as zero
    @(negedge clk);
    io_we = 1; io_sel = 1; io_wdata = 8'hFF;
    @(posedge clk); @(negedge clk);
    io_we = 0;
    read_sp(v);
    chk("R6 upper bits zero", v, 16'h0310);

    // R11: hold over several idle cycles
    repeat (3) @(posedge clk);
    @(negedge clk);
    read_sp(v);
    chk("R11 idle hold", v, 16'h0310);
    chk("R11 idle addr0", {6'h0, addr0}, 16'h0310);

    // R8: 8-bit instance has no high byte
    @(negedge clk);
    io_sel8 = 1; #1 chk("R8 high byte reads zero", {8'h00, io_rdata8}, 16'h0000);
    io_we8 = 1; io_wdata8 = 8'hAA;
    @(posedge clk); @(negedge clk);
    io_we8 = 0;
    io_sel8 = 1; #1 chk("R8 high write ignored hi", {8'h00, io_rdata8}, 16'h0000);
    io_sel8 = 0; #1 chk("R8 high write ignored lo", {8'h00, io_rdata8}, 16'h00F0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule